// File: doc/BRIEF.md
# MESI Cache Read-Miss Controller

This block handles processor reads for one private cache in a snooping multiprocessor that keeps the caches coherent with MESI. It holds a small direct-mapped array with one tag and one 2-bit coherence state for each line. Each accepted read is looked up in that array. A hit is reported one cycle later and does not change the line's state. A miss places a read request on the snoop bus. The controller then stalls until the peers return a snoop response.

The response says whether a peer supplied the data and how that peer held the line. The controller fills the line as Shared when a peer supplied the data, and as Exclusive when memory did. It writes the requested tag into the line, pulses a completion strobe, and updates a bank of event counters. The counters split misses by cause and by the state of the peer that supplied the data.

The address is split into a line index in the low `IDX_W` bits and a tag in the `TAG_W` bits above it. Writes, evictions, writebacks and data storage are handled elsewhere.

Top module: `mesi_read_ctrl`

## Requirements
- R1: After reset every line is Invalid with a stored tag of 0. `busy`, `hit_pulse`, `done_pulse` and `bus_req` are low, and all counters are zero.
- R2: An accepted read misses when the stored tag at its index differs from the read's tag, or when the tags match but the line is Invalid. On a miss, `bus_req` pulses for one cycle in the cycle after acceptance, with `bus_addr` equal to the read address. `cnt_miss` and `cnt_req` each increase by one.
- R3: A miss whose tag matched an Invalid line also increments `cnt_inv_miss`. A miss caused by a tag mismatch leaves `cnt_inv_miss` unchanged.
- R4: A read whose tag matches a line that is not Invalid is a hit. `hit_pulse` rises in the cycle after acceptance and `hit_state` shows the line's state. No bus request is made, `cnt_hit` increases by one, and repeated hits return the same state.
- R5: If the snoop response has `snp_provided` = 1, the line is filled as Shared and `cnt_peer` increases by one. `cnt_peer_shr` also increases when `snp_shared` = 1. `cnt_peer_mod` also increases when both `snp_shared` and `snp_exclusive` are 0.
- R6: If the snoop response has `snp_provided` = 0, the line is filled as Exclusive and no peer counter changes.
- R7: `busy` is high from the cycle after a miss is accepted until the cycle after the snoop response. Reads presented while `busy` is high are ignored: they cause no hit pulse, no bus request and no counter change.
- R8: A snoop response that arrives while no miss is outstanding has no effect. It produces no done pulse and changes no line.
- R9: `done_pulse` is high for exactly the one cycle after the snoop response, and `fill_state` then shows the filled state. The requested tag is stored, so a later read of the same address hits with that state. A different tag at the same index replaces it.
- R10: States are encoded on 2 bits as Invalid = 0, Shared = 1, Exclusive = 2 and Modified = 3. `hit_state` and `fill_state` use this encoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_valid | input | 1 | Read request; taken when busy is low |
| rd_addr | input | TAG_W+IDX_W | Read address {tag, index} |
| busy | output | 1 | A miss is outstanding; reads are not taken |
| hit_pulse | output | 1 | One-cycle strobe: the accepted read hit |
| hit_state | output | 2 | Line state reported with hit_pulse |
| bus_req | output | 1 | One-cycle read request on the snoop bus |
| bus_addr | output | TAG_W+IDX_W | Address of the outstanding miss |
| snp_valid | input | 1 | One-cycle snoop response strobe |
| snp_provided | input | 1 | A peer supplied the data |
| snp_shared | input | 1 | The supplying peer held the line Shared |
| snp_exclusive | input | 1 | The supplying peer held the line Exclusive |
| done_pulse | output | 1 | One-cycle strobe: miss fill complete |
| fill_state | output | 2 | State written by the last fill |
| cnt_hit | output | CNT_W | Read hits |
| cnt_miss | output | CNT_W | Read misses |
| cnt_inv_miss | output | CNT_W | Misses on a matching but Invalid line |
| cnt_req | output | CNT_W | Bus read requests sent |
| cnt_peer | output | CNT_W | Misses serviced by a peer cache |
| cnt_peer_shr | output | CNT_W | Misses serviced by a Shared peer |
| cnt_peer_mod | output | CNT_W | Misses serviced by a Modified peer |

## Verification
The hardest case to reach from the ports is a miss on a line whose tag matches but whose state is Invalid. The block never invalidates a line on its own, so this case exists only right after reset, for addresses whose tag is 0. The stimulus therefore makes its first read to tag 0, before any fill has happened. It later misses on that same index with a different tag, to show that a mismatch does not touch the invalid-miss counter. Stalled reads and a stray snoop pulse are driven while the scoreboard queue is empty or holds only the outstanding fill. Any spurious strobe from the block then shows up as an unexpected pop.

// File: rtl/mesi_rd_pkg.sv
package mesi_rd_pkg;

    typedef enum logic [1:0] {
        ST_INV = 2'd0,
        ST_SHR = 2'd1,
        ST_EXC = 2'd2,
        ST_MOD = 2'd3
    } line_st_e;

    typedef struct packed {
        logic valid;
        logic provided;
        logic shared;
        logic exclusive;
    } snoop_rsp_t;

    localparam int EV_HIT   = 0;
    localparam int EV_MISS  = 1;
    localparam int EV_INVM  = 2;
    localparam int EV_REQ   = 3;
    localparam int EV_PEER  = 4;
    localparam int EV_SHR   = 5;
    localparam int EV_MOD   = 6;
    localparam int NUM_EV   = 7;

    function automatic line_st_e fill_of(input snoop_rsp_t r);
        return r.provided ? ST_SHR : ST_EXC;
    endfunction

endpackage

// File: rtl/mesi_tag_array.sv
module mesi_tag_array
    import mesi_rd_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic             lk_inv_match,
    output line_st_e         lk_state,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  line_st_e         wr_state
);
    localparam int DEPTH = 1 << IDX_W;

    logic [TAG_W-1:0] tags   [DEPTH];
    line_st_e         states [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                tags[i]   <= '0;
                states[i] <= ST_INV;
            end
        end else if (wr_en) begin
            tags[wr_idx]   <= wr_tag;
            states[wr_idx] <= wr_state;
        end
    end

    logic tag_eq;
    always_comb begin
        tag_eq       = (tags[lk_idx] == lk_tag);
        lk_state     = states[lk_idx];
        lk_hit       = tag_eq && (states[lk_idx] != ST_INV);
        lk_inv_match = tag_eq && (states[lk_idx] == ST_INV);
    end

    // R9: a fill leaves a valid line behind
    a_r9_fill_valid: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> states[$past(wr_idx)] != ST_INV);

endmodule

// File: rtl/mesi_miss_fsm.sv
module mesi_miss_fsm
    import mesi_rd_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              lk_hit,
    input  logic              lk_inv_match,
    input  line_st_e          lk_state,
    input  snoop_rsp_t        snp,
    output logic              busy,
    output logic              hit_pulse,
    output line_st_e          hit_state,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              done_pulse,
    output line_st_e          fill_state,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output line_st_e          wr_state,
    output logic [NUM_EV-1:0] ev
);
    typedef enum logic {S_IDLE, S_WAIT} fsm_e;

    fsm_e              st;
    logic [ADDR_W-1:0] miss_addr;
    logic              accept;
    logic              resolve;

    assign accept  = rd_valid && (st == S_IDLE);
    assign resolve = snp.valid && (st == S_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= S_IDLE;
            miss_addr  <= '0;
            hit_pulse  <= 1'b0;
            hit_state  <= ST_INV;
            bus_req    <= 1'b0;
            done_pulse <= 1'b0;
            fill_state <= ST_INV;
        end else begin
            hit_pulse  <= 1'b0;
            bus_req    <= 1'b0;
            done_pulse <= 1'b0;
            case (st)
                S_IDLE: if (accept) begin
                    if (lk_hit) begin
                        hit_pulse <= 1'b1;
                        hit_state <= lk_state;
                    end else begin
                        bus_req   <= 1'b1;
                        miss_addr <= rd_addr;
                        st        <= S_WAIT;
                    end
                end
                S_WAIT: if (resolve) begin
                    done_pulse <= 1'b1;
                    fill_state <= fill_of(snp);
                    st         <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        busy     = (st == S_WAIT);
        bus_addr = miss_addr;
        wr_en    = resolve;
        wr_addr  = miss_addr;
        wr_state = fill_of(snp);
        ev           = '0;
        ev[EV_HIT]   = accept && lk_hit;
        ev[EV_MISS]  = accept && !lk_hit;
        ev[EV_INVM]  = accept && lk_inv_match;
        ev[EV_REQ]   = accept && !lk_hit;
        ev[EV_PEER]  = resolve && snp.provided;
        ev[EV_SHR]   = resolve && snp.provided && snp.shared;
        ev[EV_MOD]   = resolve && snp.provided && !snp.shared && !snp.exclusive;
    end

    // R2: a miss puts a request on the bus next cycle
    a_r2_req_after_miss: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !busy && !lk_hit) |=> (bus_req && busy));
    // R4: hits never go to the bus
    a_r4_hit_no_req: assert property (@(posedge clk) disable iff (rst)
        hit_pulse |-> (!bus_req && !busy));
    // R7: no hit reported while a miss is outstanding
    a_r7_stall: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_valid && !snp.valid) |=> (!hit_pulse && busy));
    // R5: supplied data fills Shared
    a_r5_fill_shared: assert property (@(posedge clk) disable iff (rst)
        (busy && snp.valid && snp.provided) |=> (done_pulse && fill_state == ST_SHR && !busy));
    // R6: memory data fills Exclusive
    a_r6_fill_excl: assert property (@(posedge clk) disable iff (rst)
        (busy && snp.valid && !snp.provided) |=> (done_pulse && fill_state == ST_EXC));
    // R8: idle snoop produces no completion
    a_r8_stray_snoop: assert property (@(posedge clk) disable iff (rst)
        (!busy && snp.valid) |=> !done_pulse);

endmodule

// File: rtl/mesi_evt_counters.sv
module mesi_evt_counters
    import mesi_rd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_EV-1:0]            ev,
    output logic [NUM_EV-1:0][CNT_W-1:0] cnt
);
    for (genvar g = 0; g < NUM_EV; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst)        cnt[g] <= '0;
            else if (ev[g]) cnt[g] <= cnt[g] + 1'b1;
        end
    end

    // R5: peer-serviced misses never exceed misses; split counts never exceed peer count
    a_r5_peer_le_miss: assert property (@(posedge clk) disable iff (rst)
        cnt[EV_PEER] <= cnt[EV_MISS]);
    a_r5_split_le_peer: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, cnt[EV_SHR]} + {1'b0, cnt[EV_MOD]}) <= {1'b0, cnt[EV_PEER]});

endmodule

// File: rtl/mesi_read_ctrl.sv
module mesi_read_ctrl
    import mesi_rd_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 6,
    parameter int CNT_W  = 16,
    localparam int ADDR_W = TAG_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              busy,
    output logic              hit_pulse,
    output logic [1:0]        hit_state,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              snp_valid,
    input  logic              snp_provided,
    input  logic              snp_shared,
    input  logic              snp_exclusive,
    output logic              done_pulse,
    output logic [1:0]        fill_state,
    output logic [CNT_W-1:0]  cnt_hit,
    output logic [CNT_W-1:0]  cnt_miss,
    output logic [CNT_W-1:0]  cnt_inv_miss,
    output logic [CNT_W-1:0]  cnt_req,
    output logic [CNT_W-1:0]  cnt_peer,
    output logic [CNT_W-1:0]  cnt_peer_shr,
    output logic [CNT_W-1:0]  cnt_peer_mod
);
    snoop_rsp_t                   snp;
    logic                         lk_hit, lk_inv_match;
    line_st_e                     lk_state, hit_st, fill_st, wr_state;
    logic                         wr_en;
    logic [ADDR_W-1:0]            wr_addr;
    logic [NUM_EV-1:0]            ev;
    logic [NUM_EV-1:0][CNT_W-1:0] cnt;

    assign snp = '{valid: snp_valid, provided: snp_provided,
                   shared: snp_shared, exclusive: snp_exclusive};

    mesi_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_array (
        .clk          (clk),
        .rst          (rst),
        .lk_idx       (rd_addr[IDX_W-1:0]),
        .lk_tag       (rd_addr[ADDR_W-1:IDX_W]),
        .lk_hit       (lk_hit),
        .lk_inv_match (lk_inv_match),
        .lk_state     (lk_state),
        .wr_en        (wr_en),
        .wr_idx       (wr_addr[IDX_W-1:0]),
        .wr_tag       (wr_addr[ADDR_W-1:IDX_W]),
        .wr_state     (wr_state)
    );

    mesi_miss_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .rd_valid     (rd_valid),
        .rd_addr      (rd_addr),
        .lk_hit       (lk_hit),
        .lk_inv_match (lk_inv_match),
        .lk_state     (lk_state),
        .snp          (snp),
        .busy         (busy),
        .hit_pulse    (hit_pulse),
        .hit_state    (hit_st),
        .bus_req      (bus_req),
        .bus_addr     (bus_addr),
        .done_pulse   (done_pulse),
        .fill_state   (fill_st),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_state     (wr_state),
        .ev           (ev)
    );

    mesi_evt_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .ev  (ev),
        .cnt (cnt)
    );

    assign hit_state    = hit_st;
    assign fill_state   = fill_st;
    assign cnt_hit      = cnt[EV_HIT];
    assign cnt_miss     = cnt[EV_MISS];
    assign cnt_inv_miss = cnt[EV_INVM];
    assign cnt_req      = cnt[EV_REQ];
    assign cnt_peer     = cnt[EV_PEER];
    assign cnt_peer_shr = cnt[EV_SHR];
    assign cnt_peer_mod = cnt[EV_MOD];

    // R2: every miss sends exactly one request
    a_r2_req_eq_miss: assert property (@(posedge clk) disable iff (rst)
        cnt_req == cnt_miss);
    // R3: invalid-line misses are a subset of misses
    a_r3_inv_le_miss: assert property (@(posedge clk) disable iff (rst)
        cnt_inv_miss <= cnt_miss);

endmodule

// File: tb/tb_mesi_read_ctrl.sv
module tb_mesi_read_ctrl;
    localparam int IDX_W = 3;
    localparam int TAG_W = 6;
    localparam int CNT_W = 16;
    localparam int AW    = TAG_W + IDX_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;   // 50 MHz

    logic          rd_valid = 1'b0;
    logic [AW-1:0] rd_addr  = '0;
    logic          snp_valid = 1'b0, snp_provided = 1'b0, snp_shared = 1'b0, snp_exclusive = 1'b0;
    logic          busy, hit_pulse, bus_req, done_pulse;
    logic [1:0]    hit_state, fill_state;
    logic [AW-1:0] bus_addr;
    logic [CNT_W-1:0] c_hit, c_miss, c_inv, c_req, c_peer, c_shr, c_mod;

    mesi_read_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_addr(rd_addr),
        .busy(busy), .hit_pulse(hit_pulse), .hit_state(hit_state),
        .bus_req(bus_req), .bus_addr(bus_addr),
        .snp_valid(snp_valid), .snp_provided(snp_provided),
        .snp_shared(snp_shared), .snp_exclusive(snp_exclusive),
        .done_pulse(done_pulse), .fill_state(fill_state),
        .cnt_hit(c_hit), .cnt_miss(c_miss), .cnt_inv_miss(c_inv), .cnt_req(c_req),
        .cnt_peer(c_peer), .cnt_peer_shr(c_shr), .cnt_peer_mod(c_mod)
    );

    localparam logic [1:0] INV = 2'd0, SHR = 2'd1, EXC = 2'd2;

    typedef struct { bit is_hit; logic [1:0] st; string req; } item_t;
    item_t exp_q[$];

    int n_chk = 0, n_fail = 0;
    int m_hit = 0, m_miss = 0, m_inv = 0, m_peer = 0, m_shr = 0, m_mod = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // monitor: pops expected results as strobes appear
    always @(negedge clk) begin
        if (!rst && (hit_pulse || done_pulse)) begin
            item_t e;
            if (exp_q.size() == 0) begin
                check(1'b0, "R7/R8", "unexpected strobe", {hit_pulse, done_pulse}, 0);
            end else begin
                e = exp_q.pop_front();
                check(hit_pulse == e.is_hit, e.req, "strobe kind", hit_pulse, e.is_hit);
                check((e.is_hit ? hit_state : fill_state) == e.st, e.req,
                      "reported state (R10)", e.is_hit ? hit_state : fill_state, e.st);
            end
        end
    end

    task automatic do_read(input int tag, input int idx, input bit exp_hit,
                           input logic [1:0] hit_st, input bit prov, input bit shr,
                           input bit exc, input int dly, input string req);
        item_t it;
        logic [AW-1:0] a;
        a = AW'((tag << IDX_W) | idx);
        it.is_hit = exp_hit;
        it.st     = exp_hit ? hit_st : (prov ? SHR : EXC);
        it.req    = req;
        exp_q.push_back(it);
        @(negedge clk);
        rd_valid = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_valid = 1'b0;
        check(bus_req == !exp_hit, req, "bus_req after accept (R2/R4)", bus_req, !exp_hit);
        if (exp_hit) begin
            m_hit++;
        end else begin
            m_miss++;
            check(bus_addr == a, "R2", "bus_addr", bus_addr, a);
            check(busy == 1'b1, "R7", "busy during miss", busy, 1);
            repeat (dly) @(negedge clk);
            snp_valid = 1'b1; snp_provided = prov; snp_shared = shr; snp_exclusive = exc;
            @(negedge clk);
            snp_valid = 1'b0; snp_provided = 1'b0; snp_shared = 1'b0; snp_exclusive = 1'b0;
            check(busy == 1'b0 && done_pulse, "R9", "busy drop with done", busy, 0);
            if (prov) begin
                m_peer++;
                if (shr) m_shr++;
                else if (!exc) m_mod++;
            end
        end
    endtask

    task automatic check_counters(input string tag);
        check(c_hit  == m_hit,  "R4", {tag, " cnt_hit"}, c_hit, m_hit);
        check(c_miss == m_miss, "R2", {tag, " cnt_miss"}, c_miss, m_miss);
        check(c_req  == m_miss, "R2", {tag, " cnt_req"}, c_req, m_miss);
        check(c_inv  == m_inv,  "R3", {tag, " cnt_inv_miss"}, c_inv, m_inv);
        check(c_peer == m_peer, "R5", {tag, " cnt_peer"}, c_peer, m_peer);
        check(c_shr  == m_shr,  "R5", {tag, " cnt_peer_shr"}, c_shr, m_shr);
        check(c_mod  == m_mod,  "R5", {tag, " cnt_peer_mod"}, c_mod, m_mod);
    endtask

    bit done_flag = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(!busy && !hit_pulse && !done_pulse && !bus_req, "R1", "idle outputs",
              {busy, hit_pulse, done_pulse, bus_req}, 0);
        check_counters("R1 reset");

        // R3: tag 0 matches Invalid line after reset; memory fill -> Exclusive (R6)
        m_inv++;
        do_read(0, 0, 0, INV, 0, 0, 0, 3, "R3");
        do_read(0, 0, 1, EXC, 0, 0, 0, 0, "R4");
        // R5: shared peer supplies, zero-delay snoop
        do_read(5, 1, 0, INV, 1, 1, 0, 0, "R5");
        do_read(5, 1, 1, SHR, 0, 0, 0, 0, "R4");
        do_read(5, 1, 1, SHR, 0, 0, 0, 0, "R4");
        // R5: exclusive peer supplies; then modified peer
        do_read(7, 2, 0, INV, 1, 0, 1, 2, "R5");
        do_read(9, 3, 0, INV, 1, 0, 0, 5, "R5");
        do_read(9, 3, 1, SHR, 0, 0, 0, 0, "R9");
        check_counters("mid");

        // R7: reads presented while busy are ignored
        begin
            item_t it;
            it.is_hit = 0; it.st = EXC; it.req = "R7";
            exp_q.push_back(it);
            @(negedge clk);
            rd_valid = 1'b1; rd_addr = AW'((3 << IDX_W) | 4);
            @(negedge clk);
            m_miss++;
            rd_addr = AW'((5 << IDX_W) | 1);    // would hit if accepted
            repeat (4) @(negedge clk);
            check(bus_req == 1'b0 && busy, "R7", "no request while stalled", bus_req, 0);
            rd_valid = 1'b0;
            check(c_hit == m_hit, "R7", "cnt_hit unchanged while busy", c_hit, m_hit);
            snp_valid = 1'b1;
            @(negedge clk);
            snp_valid = 1'b0;
            check(!busy, "R7", "busy released", busy, 0);
        end

        // R8: stray snoop while idle
        repeat (2) @(negedge clk);
        snp_valid = 1'b1; snp_provided = 1'b1; snp_shared = 1'b1;
        @(negedge clk);
        snp_valid = 1'b0; snp_provided = 1'b0; snp_shared = 1'b0;
        check(!done_pulse && !busy, "R8", "no completion from stray snoop", done_pulse, 0);
        do_read(3, 4, 1, EXC, 0, 0, 0, 0, "R8");

        // R9: replacement at index 0; mismatch miss does not touch inv counter (R3)
        do_read(10, 0, 0, INV, 0, 0, 0, 1, "R9");
        do_read(0, 0, 0, INV, 1, 0, 0, 0, "R3");
        do_read(0, 0, 1, SHR, 0, 0, 0, 0, "R9");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R9", "all expected strobes seen", exp_q.size(), 0);
        check_counters("final");
        done_flag = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(negedge clk);
        if (!done_flag) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule